// File: doc/BRIEF.md
# Buffered Variable-Period PWM Timer

This block produces a single pulse-width-modulated output from an 8-bit up counter. The counter runs over a period of 64, 128 or 256 counts, picked by a mode field. A compare value sets where in the period the output changes level. The output is held in a toggle flip-flop. That flip-flop inverts once when the counter reaches the compare value and once when the period wraps. The high time within each period is therefore the period length minus the compare value, counted in ticks.

Software writes two registers through a simple write-only port. The first is a control word that holds run, buffering, toggle enable, count-source select and period mode. The second is the compare value. With buffering on, a new compare value waits in a holding register and moves into use only when the period wraps. A running period therefore never sees a changed duty point part way through. The count source can be a synchronised external pin or one of three internal tick enables. Each wrap raises a one-cycle interrupt pulse. A configuration-error flag warns when the compare value cannot produce a valid pulse.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset, `pwm_out`, `irq` and `cfg_err` are low, the counter and both compare registers are zero, and run is off.
- R2: Control bits [6:5] set the period: 01 gives 64 ticks, 10 gives 128 ticks, 00 and 11 give 256 ticks. The counter wraps to zero after the last count, and `irq` is high for exactly one clock at each wrap.
- R3: While toggling is enabled, the output inverts on the tick that brings the counter to the compare value and on the wrap tick. Starting from a low output, the output is high for (period − compare) ticks in every period.
- R4: Control bits [4:3] pick the count source: 00 counts rising edges of `ext_in` after a two-flop synchroniser, 01 uses `tick_div1`, 10 uses `tick_div4` and 11 uses `tick_div16`.
- R5: Control bit 0 is run. While it is 0, the counter stays at zero, no `irq` occurs and `pwm_out` holds its level. When run is set again, counting restarts from zero.
- R6: With control bit 1 (buffer enable) clear, a compare write (`wr_sel`=1) takes effect on the following clock, including within the current period.
- R7: With buffer enable set, a compare write is held and only reaches the comparator at the next wrap. The current period still uses the old value.
- R8: With control bit 2 (toggle enable) clear, `pwm_out` keeps its level while counting and `irq` continue.
- R9: `cfg_err` is high when run is set and the compare value is zero or not below the selected period.
- R10: When a compare match and a wrap fall on the same tick (compare value zero), the output inverts only once, so it changes level once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the compare value |
| wr_data | input | 8 | Write data |
| ext_in | input | 1 | External count input, asynchronous |
| tick_div1 | input | 1 | Internal count enable, every clock |
| tick_div4 | input | 1 | Internal count enable, every fourth clock |
| tick_div16 | input | 1 | Internal count enable, every sixteenth clock |
| pwm_out | output | 1 | PWM output from the toggle flip-flop |
| irq | output | 1 | One-clock pulse at each period wrap |
| cfg_err | output | 1 | Compare value is invalid for the running period |

## Verification
The bench targets a compare write that lands just after a wrap. A design that ignored the buffer enable would shorten the pulse in that same period, and one that never loaded the buffer would keep the old width forever. It sets a compare value of zero so that match and wrap coincide: a design that inverted twice would leave the output flat instead of changing level once per period. It stops and restarts the counter and checks that the first rising edge comes exactly compare-value ticks after restart, which a counter that kept its old count would miss. It checks the upper bound of the period: a compare value of 64 in the 64-count mode must raise the error flag, while 63 must not.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SRC_EXT   = 2'b00,
        SRC_DIV1  = 2'b01,
        SRC_DIV4  = 2'b10,
        SRC_DIV16 = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        PER_FULL_A = 2'b00,
        PER_QUART  = 2'b01,
        PER_HALF   = 2'b10,
        PER_FULL_B = 2'b11
    } per_mode_e;

    // Control word layout, most significant field first
    typedef struct packed {
        per_mode_e mode;     // [6:5]
        src_sel_e  src;      // [4:3]
        logic      tog_en;   // [2]
        logic      buf_en;   // [1]
        logic      run;      // [0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
    import pwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_in,
    input  logic     tick_div1,
    input  logic     tick_div4,
    input  logic     tick_div16,
    input  src_sel_e src,
    output logic     tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_tick_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_in;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            ext_tick_q <= 1'b0;
        end else begin
            prev_q     <= sync_q[SYNC_STAGES-1];
            ext_tick_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
        end
    end

    always_comb begin
        unique case (src)
            SRC_EXT:   tick = ext_tick_q;
            SRC_DIV1:  tick = tick_div1;
            SRC_DIV4:  tick = tick_div4;
            SRC_DIV16: tick = tick_div16;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wrap,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] hold_q
);

    logic wr_ctrl;
    logic wr_cmp;

    assign wr_ctrl = wr_en & ~wr_sel;
    assign wr_cmp  = wr_en &  wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // Holding register follows every compare write in both modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else if (wr_cmp) hold_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (ctrl.buf_en) begin
            if (wrap) cmp_q <= hold_q;
        end else if (wr_cmp) begin
            cmp_q <= wr_data;
        end
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             tog_en,
    input  per_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap,
    output logic             pwm_q,
    output logic             irq_q,
    output logic             cfg_err
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt_next;
    logic             step;
    logic             match;
    logic             flip;

    always_comb begin
        unique case (mode)
            PER_QUART: last = ALL_ONES >> 2;
            PER_HALF:  last = ALL_ONES >> 1;
            default:   last = ALL_ONES;
        endcase
    end

    always_comb begin
        step     = tick & run;
        wrap     = step & (cnt_q >= last);
        cnt_next = wrap ? '0 : cnt_q + CNT_W'(1);
        match    = step & (cnt_next == cmp);
        flip     = tog_en & (match | wrap);
        cfg_err  = run & ((cmp == '0) | (cmp > last));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (step) cnt_q <= cnt_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (flip) pwm_q <= ~pwm_q;
        end
    end

endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_in,
    input  logic             tick_div1,
    input  logic             tick_div4,
    input  logic             tick_div16,
    output logic             pwm_out,
    output logic             irq,
    output logic             cfg_err
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             tick;
    logic             run_q;
    logic             tog_q;
    logic             bufen_q;

    assign run_q   = ctrl.run;
    assign tog_q   = ctrl.tog_en;
    assign bufen_q = ctrl.buf_en;

    pwm_cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wrap    (wrap),
        .ctrl    (ctrl),
        .cmp_q   (cmp_q),
        .hold_q  (hold_q)
    );

    pwm_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_in     (ext_in),
        .tick_div1  (tick_div1),
        .tick_div4  (tick_div4),
        .tick_div16 (tick_div16),
        .src        (ctrl.src),
        .tick       (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run_q),
        .tog_en  (tog_q),
        .mode    (ctrl.mode),
        .cmp     (cmp_q),
        .cnt_q   (cnt_q),
        .wrap    (wrap),
        .pwm_q   (pwm_out),
        .irq_q   (irq),
        .cfg_err (cfg_err)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             pwm_out,
    input logic             run_q,
    input logic             tog_q,
    input logic             bufen_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] hold_q
);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R2

    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_q == '0)); // R2

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (cnt_q == '0) && !irq); // R5

    AST_FROZEN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_q |=> $stable(pwm_out)); // R8

    AST_BUFFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(bufen_q)) |-> (cmp_q == $past(hold_q))); // R7

endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .pwm_out (pwm_out),
    .run_q   (run_q),
    .tog_q   (tog_q),
    .bufen_q (bufen_q),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .hold_q  (hold_q)
);

// File: tb/tb_pwm_timer_top.sv
`timescale 1ns/1ps
module tb_pwm_timer_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_in;
    logic       tick_div1 = 1'b1;
    logic       tick_div4;
    logic       tick_div16;
    logic       pwm_out;
    logic       irq;
    logic       cfg_err;
    logic [3:0] div_ctr = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) div_ctr <= div_ctr + 4'd1;
    assign tick_div4  = (div_ctr[1:0] == 2'd0);
    assign tick_div16 = (div_ctr == 4'd0);
    assign ext_in     = div_ctr[1];

    pwm_timer_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ext_in     (ext_in),
        .tick_div1  (tick_div1),
        .tick_div4  (tick_div4),
        .tick_div16 (tick_div16),
        .pwm_out    (pwm_out),
        .irq        (irq),
        .cfg_err    (cfg_err)
    );

    // control word: {mode[1:0], src[1:0], tog, buf, run}
    function automatic logic [7:0] cw(input logic [1:0] mode, input logic [1:0] src,
                                      input logic tog, input logic bf, input logic run);
        return {1'b0, mode, src, tog, bf, run};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for a rising edge of pwm_out, returns the number of cycles it stays high
    task automatic measure_high(output int w);
        int t;
        logic prev;
        w = -1;
        prev = pwm_out;
        t = 0;
        while (!(pwm_out && !prev) && t < 6000) begin
            prev = pwm_out;
            @(negedge clk);
            t++;
        end
        if (t >= 6000) return;
        w = 0;
        while (pwm_out && w < 6000) begin
            w++;
            @(negedge clk);
        end
    endtask

    // Cycles between consecutive irq pulses; width of the pulse
    task automatic measure_irq(output int gap, output int width);
        int t;
        gap = -1; width = -1;
        t = 0;
        while (!irq && t < 6000) begin @(negedge clk); t++; end
        if (t >= 6000) return;
        width = 0;
        while (irq && width < 10) begin width++; @(negedge clk); end
        gap = width;
        while (!irq && gap < 6000) begin gap++; @(negedge clk); end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pwm_out", pwm_out, 0);
        check("R1 irq", irq, 0);
        check("R1 cfg_err", cfg_err, 0);
    endtask

    task automatic t_period(input logic [1:0] mode, input int cmp, input int per);
        int w, g, pw;
        do_reset();
        wr(1'b1, 8'(cmp));
        wr(1'b0, cw(mode, 2'b01, 1'b1, 1'b0, 1'b1));
        measure_high(w);
        check("R3 high width", w, per - cmp);
        measure_irq(g, pw);
        check("R2 period", g, per);
        check("R2 irq width", pw, 1);
    endtask

    task automatic t_source(input logic [1:0] src, input int scale);
        int w;
        do_reset();
        wr(1'b1, 8'd16);
        wr(1'b0, cw(2'b01, src, 1'b1, 1'b0, 1'b1));
        measure_high(w);
        check("R4 source scaled width", w, 48 * scale);
    endtask

    task automatic t_run();
        int w, n_irq, n_chg, low;
        logic p0;
        do_reset();
        wr(1'b1, 8'd16);
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b1));
        measure_high(w);
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b0));
        p0 = pwm_out; n_irq = 0; n_chg = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq) n_irq++;
            if (pwm_out != p0) n_chg++;
        end
        check("R5 no irq when stopped", n_irq, 0);
        check("R5 output held when stopped", n_chg, 0);
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b1));
        low = 0;
        while (!pwm_out && low < 500) begin low++; @(negedge clk); end
        check("R5 restart from zero", low, 16);
    endtask

    task automatic t_buffer(input logic bf);
        int w;
        do_reset();
        wr(1'b1, 8'd16);
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, bf, 1'b1));
        measure_high(w);
        wr(1'b1, 8'd40);
        measure_high(w);
        if (bf) begin
            check("R7 old value this period", w, 48);
            measure_high(w);
            check("R7 new value after wrap", w, 24);
        end else begin
            check("R6 immediate update", w, 24);
        end
    endtask

    task automatic t_toggle_off();
        int n_irq, n_chg, w;
        do_reset();
        wr(1'b1, 8'd16);
        wr(1'b0, cw(2'b01, 2'b01, 1'b0, 1'b0, 1'b1));
        n_irq = 0; n_chg = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (irq) n_irq++;
            if (pwm_out) n_chg++;
        end
        check("R8 output frozen", n_chg, 0);
        check("R8 irq continues", n_irq, 4);
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b1));
        measure_high(w);
        check("R8 toggling resumes", w, 48);
    endtask

    task automatic t_cfg();
        do_reset();
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b1));
        check("R9 compare zero", cfg_err, 1);
        wr(1'b1, 8'd64);
        check("R9 compare at period", cfg_err, 1);
        wr(1'b1, 8'd63);
        check("R9 compare below period", cfg_err, 0);
        wr(1'b1, 8'd64);
        wr(1'b0, cw(2'b10, 2'b01, 1'b1, 1'b0, 1'b1));
        check("R9 longer period", cfg_err, 0);
        wr(1'b1, 8'd0);
        wr(1'b0, cw(2'b10, 2'b01, 1'b1, 1'b0, 1'b0));
        check("R9 stopped", cfg_err, 0);
    endtask

    task automatic t_coincide();
        int w;
        do_reset();
        wr(1'b0, cw(2'b01, 2'b01, 1'b1, 1'b0, 1'b1));
        measure_high(w);
        check("R10 single inversion", w, 64);
    endtask

    initial begin
        #750000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_period(2'b01, 16, 64);
        t_period(2'b10, 100, 128);
        t_period(2'b11, 100, 256);
        t_period(2'b00, 200, 256);
        t_source(2'b10, 4);
        t_source(2'b11, 16);
        t_source(2'b00, 4);
        t_run();
        t_buffer(1'b0);
        t_buffer(1'b1);
        t_toggle_off();
        t_cfg();
        t_coincide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule